// File: doc/BRIEF.md
# Immediate-Operand Quirk Logic Unit

This unit produces the results of a group of irregular 8-bit instructions that take an immediate operand. For each strobed request it takes an opcode byte, the immediate byte, the current accumulator and index register values, and the current negative, zero, carry and overflow flags. It returns the new accumulator, the new index register, the four updated flags and one write enable for each register. Arithmetic is binary only. Where the hardware behaviour varies from one machine to another, the unit models a single fixed, deterministic variant.

Each accepted request produces a result one clock edge later, in a register stage. The unit does not combine results across requests, but every output holds its last value until the next strobe. An opcode outside the supported set sets the illegal indication. In that case every register and flag output is a copy of its input, and both write enables stay low. The surrounding datapath can therefore commit the outputs unconditionally or gate them with the enables.

Top module: `quirk_imm_unit`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: Opcodes 0x0B and 0x2B set acc_o = acc_i AND imm_i. N is acc_o bit 7, Z is (acc_o == 0), C equals the new N, and V passes through from ovf_i.
- R3: Opcode 0x4B computes t = acc_i AND imm_i and sets acc_o = t shifted right by one with bit 7 cleared. C takes t bit 0, N is 0, and V passes through from ovf_i.
- R4: Opcode 0x6B computes t = acc_i AND imm_i and sets acc_o = {carry_i, t[7:1]}. C takes t bit 7, V is t[7] XOR t[6], and bit 0 of t is dropped.
- R5: Opcode 0xCB sets xreg_o = ((acc_i AND xreg_i) − imm_i) mod 256 and ignores carry_i. C is 1 exactly when (acc_i AND xreg_i) >= imm_i, V passes through from ovf_i, and acc_o equals acc_i.
- R6: Opcode 0x8B sets acc_o = xreg_i AND imm_i. C and V pass through from their inputs.
- R7: Opcode 0xAB sets acc_o = xreg_o = (acc_i OR 0xEE) AND imm_i. C and V pass through from their inputs.
- R8: Opcode 0xEB sets acc_o = acc_i − imm_i − (1 − carry_i) mod 256. C is the adder carry-out of acc_i + NOT imm_i + carry_i, and V is signed overflow, bit 7 of (acc_i XOR imm_i) AND (acc_i XOR acc_o).
- R9: For every supported opcode, N and Z describe the final value written to the destination register: xreg_o for 0xCB, acc_o for all others.
- R10: acc_we_o is 1 only for 0x0B, 0x2B, 0x4B, 0x6B, 0x8B, 0xAB and 0xEB. xreg_we_o is 1 only for 0xCB and 0xAB.
- R11: For any other opcode, illegal_o is 1, both write enables are 0, and acc_o, xreg_o and all four flags equal their inputs. For supported opcodes, illegal_o is 0.
- R12: Results appear on the outputs at the first rising edge after valid_i is sampled high. While valid_i is low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Instruction opcode byte |
| imm_i | input | 8 | Immediate operand byte |
| acc_i | input | 8 | Current accumulator |
| xreg_i | input | 8 | Current index register |
| neg_i | input | 1 | Current N flag |
| zero_i | input | 1 | Current Z flag |
| carry_i | input | 1 | Current C flag |
| ovf_i | input | 1 | Current V flag |
| acc_o | output | 8 | New accumulator value |
| xreg_o | output | 8 | New index register value |
| flag_n_o | output | 1 | New N flag |
| flag_z_o | output | 1 | New Z flag |
| flag_c_o | output | 1 | New C flag |
| flag_v_o | output | 1 | New V flag |
| acc_we_o | output | 1 | Accumulator write enable |
| xreg_we_o | output | 1 | Index register write enable |
| illegal_o | output | 1 | Unsupported opcode indication |

## Verification
The assertions check the following on every cycle:
- outputs hold while no request is strobed;
- Z tracks the register that was written;
- N stays clear after the shift opcode;
- C mirrors N after the AND-to-carry opcodes;
- V is preserved by the compare-style subtract;
- an illegal result never carries a write enable.

Only the bench scenarios can show the actual arithmetic values, because those require known operand patterns and hand-derived results. These include:
- the carry and overflow taken from the rotate's adder internals;
- borrow with carry-in ignored;
- signed overflow of the full subtract;
- pass-through of every input on an unsupported opcode.

// File: rtl/quirk_pkg.sv
package quirk_pkg;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned OPC_W     = 8;
  localparam logic [DATA_W-1:0] LXA_MASK = 8'hEE;

  typedef enum logic [2:0] {
    OPK_ANDC  = 3'd0,  // AND, carry from bit 7
    OPK_ANDSR = 3'd1,  // AND then shift right
    OPK_ANDRR = 3'd2,  // AND then rotate with adder-style flags
    OPK_XSUB  = 3'd3,  // (A AND X) minus imm into X
    OPK_XAND  = 3'd4,  // X AND imm into A
    OPK_MAGIC = 3'd5,  // (A OR mask) AND imm into A and X
    OPK_SBC   = 3'd6,  // subtract with borrow
    OPK_NONE  = 3'd7   // unsupported
  } quirk_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] xr;
    logic              n;
    logic              z;
    logic              c;
    logic              v;
  } quirk_res_t;

endpackage

// File: rtl/quirk_decode.sv
module quirk_decode
  import quirk_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output quirk_op_e        op_o,
  output logic             acc_we_o,
  output logic             xreg_we_o,
  output logic             illegal_o
);

  always_comb begin
    op_o = OPK_NONE;
    unique case (opcode_i)
      8'h0B, 8'h2B: op_o = OPK_ANDC;
      8'h4B:        op_o = OPK_ANDSR;
      8'h6B:        op_o = OPK_ANDRR;
      8'hCB:        op_o = OPK_XSUB;
      8'h8B:        op_o = OPK_XAND;
      8'hAB:        op_o = OPK_MAGIC;
      8'hEB:        op_o = OPK_SBC;
      default:      op_o = OPK_NONE;
    endcase
  end

  always_comb begin
    acc_we_o  = 1'b0;
    xreg_we_o = 1'b0;
    illegal_o = 1'b0;
    case (op_o)
      OPK_XSUB:  xreg_we_o = 1'b1;
      OPK_MAGIC: begin
        acc_we_o  = 1'b1;
        xreg_we_o = 1'b1;
      end
      OPK_NONE:  illegal_o = 1'b1;
      default:   acc_we_o  = 1'b1;
    endcase
  end

endmodule

// File: rtl/quirk_alu.sv
module quirk_alu
  import quirk_pkg::*;
(
  input  quirk_op_e         op_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] xreg_i,
  input  logic              neg_i,
  input  logic              zero_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output quirk_res_t        res_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] and_ai;
  logic [DATA_W-1:0] and_ax;
  logic [DATA_W:0]   xsub;
  logic [DATA_W:0]   sbc_sum;
  logic [DATA_W-1:0] dest;

  always_comb begin
    and_ai  = acc_i & imm_i;
    and_ax  = acc_i & xreg_i;
    xsub    = {1'b0, and_ax} + {1'b0, ~imm_i} + {{DATA_W{1'b0}}, 1'b1};
    sbc_sum = {1'b0, acc_i} + {1'b0, ~imm_i} + {{DATA_W{1'b0}}, carry_i};
  end

  always_comb begin
    res_o = '{acc: acc_i, xr: xreg_i, n: neg_i, z: zero_i, c: carry_i, v: ovf_i};
    case (op_i)
      OPK_ANDC: begin
        res_o.acc = and_ai;
        res_o.c   = and_ai[MSB];
      end
      OPK_ANDSR: begin
        res_o.acc = {1'b0, and_ai[MSB:1]};
        res_o.c   = and_ai[0];
      end
      OPK_ANDRR: begin
        res_o.acc = {carry_i, and_ai[MSB:1]};
        res_o.c   = and_ai[MSB];
        res_o.v   = and_ai[MSB] ^ and_ai[MSB-1];
      end
      OPK_XSUB: begin
        res_o.xr = xsub[DATA_W-1:0];
        res_o.c  = xsub[DATA_W];
      end
      OPK_XAND: begin
        res_o.acc = xreg_i & imm_i;
      end
      OPK_MAGIC: begin
        res_o.acc = (acc_i | LXA_MASK) & imm_i;
        res_o.xr  = (acc_i | LXA_MASK) & imm_i;
      end
      OPK_SBC: begin
        res_o.acc = sbc_sum[DATA_W-1:0];
        res_o.c   = sbc_sum[DATA_W];
        res_o.v   = (acc_i[MSB] ^ imm_i[MSB]) & (acc_i[MSB] ^ sbc_sum[MSB]);
      end
      default: ;
    endcase
    // N and Z describe the register that receives the result
    dest = (op_i == OPK_XSUB) ? res_o.xr : res_o.acc;
    if (op_i != OPK_NONE) begin
      res_o.n = dest[MSB];
      res_o.z = (dest == '0);
    end
  end

endmodule

// File: rtl/quirk_out_reg.sv
module quirk_out_reg
  import quirk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  quirk_res_t res_i,
  input  logic       acc_we_i,
  input  logic       xreg_we_i,
  input  logic       illegal_i,
  output quirk_res_t res_o,
  output logic       acc_we_o,
  output logic       xreg_we_o,
  output logic       illegal_o
);

  quirk_res_t res_d;
  logic       acc_we_d;
  logic       xreg_we_d;
  logic       illegal_d;

  always_comb begin
    res_d     = res_o;
    acc_we_d  = acc_we_o;
    xreg_we_d = xreg_we_o;
    illegal_d = illegal_o;
    if (en_i) begin
      res_d     = res_i;
      acc_we_d  = acc_we_i;
      xreg_we_d = xreg_we_i;
      illegal_d = illegal_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      acc_we_o  <= 1'b0;
      xreg_we_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      acc_we_o  <= acc_we_d;
      xreg_we_o <= xreg_we_d;
      illegal_o <= illegal_d;
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(acc_we_o || xreg_we_o)); // R11

endmodule

// File: rtl/quirk_imm_unit.sv
module quirk_imm_unit
  import quirk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] xreg_i,
  input  logic              neg_i,
  input  logic              zero_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] xreg_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              acc_we_o,
  output logic              xreg_we_o,
  output logic              illegal_o
);

  quirk_op_e  op;
  logic       dec_acc_we;
  logic       dec_xreg_we;
  logic       dec_illegal;
  quirk_res_t alu_res;
  quirk_res_t reg_res;

  quirk_decode u_decode (
    .opcode_i  (opcode_i),
    .op_o      (op),
    .acc_we_o  (dec_acc_we),
    .xreg_we_o (dec_xreg_we),
    .illegal_o (dec_illegal)
  );

  quirk_alu u_alu (
    .op_i    (op),
    .imm_i   (imm_i),
    .acc_i   (acc_i),
    .xreg_i  (xreg_i),
    .neg_i   (neg_i),
    .zero_i  (zero_i),
    .carry_i (carry_i),
    .ovf_i   (ovf_i),
    .res_o   (alu_res)
  );

  quirk_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (valid_i),
    .res_i     (alu_res),
    .acc_we_i  (dec_acc_we),
    .xreg_we_i (dec_xreg_we),
    .illegal_i (dec_illegal),
    .res_o     (reg_res),
    .acc_we_o  (acc_we_o),
    .xreg_we_o (xreg_we_o),
    .illegal_o (illegal_o)
  );

  assign acc_o    = reg_res.acc;
  assign xreg_o   = reg_res.xr;
  assign flag_n_o = reg_res.n;
  assign flag_z_o = reg_res.z;
  assign flag_c_o = reg_res.c;
  assign flag_v_o = reg_res.v;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_o) && $stable(xreg_o) && $stable(flag_c_o) && $stable(flag_v_o))); // R12

  AST_ZERO_TRACKS_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (opcode_i == 8'hCB)) |=> (flag_z_o == (xreg_o == '0))); // R9

  AST_ANC_CARRY_IS_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ((opcode_i == 8'h0B) || (opcode_i == 8'h2B))) |=> (flag_c_o == acc_o[DATA_W-1])); // R2

  AST_SHIFT_CLEARS_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (opcode_i == 8'h4B)) |=> !flag_n_o); // R3

  AST_XSUB_KEEPS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (opcode_i == 8'hCB)) |=> (flag_v_o == $past(ovf_i) && acc_o == $past(acc_i))); // R5

  AST_ILLEGAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (opcode_i == 8'h02)) |=> (illegal_o && acc_o == $past(acc_i) && xreg_o == $past(xreg_i))); // R11

endmodule

// File: tb/quirk_imm_unit_tb.sv
module quirk_imm_unit_tb;

  // vector: op imm a x nzcv_in | exp_a exp_x exp_nzcv we(a,x) ill  (59 bits)
  localparam int NVEC = 20;
  localparam logic [58:0] VEC [NVEC] = '{
    {8'h0B, 8'hF0, 8'h8F, 8'h11, 4'b0000, 8'h80, 8'h11, 4'b1010, 2'b10, 1'b0},
    {8'h2B, 8'h0F, 8'hF0, 8'h22, 4'b0011, 8'h00, 8'h22, 4'b0101, 2'b10, 1'b0},
    {8'h4B, 8'hFF, 8'h03, 8'h00, 4'b0000, 8'h01, 8'h00, 4'b0010, 2'b10, 1'b0},
    {8'h4B, 8'h01, 8'h01, 8'h00, 4'b1001, 8'h00, 8'h00, 4'b0111, 2'b10, 1'b0},
    {8'h6B, 8'hFF, 8'hC0, 8'h00, 4'b0010, 8'hE0, 8'h00, 4'b1010, 2'b10, 1'b0},
    {8'h6B, 8'h7F, 8'hFF, 8'h00, 4'b0000, 8'h3F, 8'h00, 4'b0001, 2'b10, 1'b0},
    {8'h6B, 8'h01, 8'h01, 8'h00, 4'b0000, 8'h00, 8'h00, 4'b0100, 2'b10, 1'b0},
    {8'h6B, 8'h80, 8'h80, 8'h00, 4'b0010, 8'hC0, 8'h00, 4'b1011, 2'b10, 1'b0},
    {8'hCB, 8'h5A, 8'hFF, 8'hF0, 4'b0001, 8'hFF, 8'h96, 4'b1011, 2'b01, 1'b0},
    {8'hCB, 8'h10, 8'h0F, 8'hFF, 4'b0010, 8'h0F, 8'hFF, 4'b1000, 2'b01, 1'b0},
    {8'hCB, 8'h33, 8'h33, 8'h37, 4'b0000, 8'h33, 8'h00, 4'b0110, 2'b01, 1'b0},
    {8'h8B, 8'h44, 8'hFF, 8'hC6, 4'b0011, 8'h44, 8'hC6, 4'b0011, 2'b10, 1'b0},
    {8'h8B, 8'h00, 8'h12, 8'hFF, 4'b1000, 8'h00, 8'hFF, 4'b0100, 2'b10, 1'b0},
    {8'hAB, 8'hAA, 8'h00, 8'h55, 4'b0000, 8'hAA, 8'hAA, 4'b1000, 2'b11, 1'b0},
    {8'hAB, 8'h11, 8'h01, 8'h00, 4'b0011, 8'h01, 8'h01, 4'b0011, 2'b11, 1'b0},
    {8'hEB, 8'h01, 8'h00, 8'h00, 4'b0010, 8'hFF, 8'h00, 4'b1000, 2'b10, 1'b0},
    {8'hEB, 8'h01, 8'h80, 8'h00, 4'b0010, 8'h7F, 8'h00, 4'b0011, 2'b10, 1'b0},
    {8'hEB, 8'h01, 8'h02, 8'h00, 4'b0000, 8'h00, 8'h00, 4'b0110, 2'b10, 1'b0},
    {8'h02, 8'hFF, 8'h5A, 8'hA5, 4'b1011, 8'h5A, 8'hA5, 4'b1011, 2'b00, 1'b1},
    {8'hEA, 8'h00, 8'h00, 8'h00, 4'b0100, 8'h00, 8'h00, 4'b0100, 2'b00, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [7:0] opcode, imm, acc, xr;
  logic       n_in, z_in, c_in, v_in;
  logic [7:0] acc_o, xreg_o;
  logic       fn, fz, fc, fv, acc_we, xreg_we, illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  quirk_imm_unit u_dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid),
    .opcode_i (opcode), .imm_i (imm), .acc_i (acc), .xreg_i (xr),
    .neg_i (n_in), .zero_i (z_in), .carry_i (c_in), .ovf_i (v_in),
    .acc_o (acc_o), .xreg_o (xreg_o),
    .flag_n_o (fn), .flag_z_o (fz), .flag_c_o (fc), .flag_v_o (fv),
    .acc_we_o (acc_we), .xreg_we_o (xreg_we), .illegal_o (illegal)
  );

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h0B, 8'h2B: return "R2";
      8'h4B:        return "R3";
      8'h6B:        return "R4";
      8'hCB:        return "R5";
      8'h8B:        return "R6";
      8'hAB:        return "R7";
      8'hEB:        return "R8";
      default:      return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] im, input logic [7:0] a,
                       input logic [7:0] x, input logic [3:0] f, input logic v);
    opcode = op; imm = im; acc = a; xr = x;
    {n_in, z_in, c_in, v_in} = f;
    valid = v;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(8'h00, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state, with a request on the inputs during reset
    drive(8'hAB, 8'hFF, 8'hFF, 8'hFF, 4'b1111, 1'b1);
    @(negedge clk);
    check("R1", "reset outputs", {acc_o, xreg_o}, 16'h0000);
    check("R1", "reset flags/enables", {9'd0, fn, fz, fc, fv, acc_we, xreg_we, illegal}, 16'h0000);
    valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [58:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[58:51]);
      drive(v[58:51], v[50:43], v[42:35], v[34:27], v[26:23], 1'b1);
      @(negedge clk);
      check(t, "acc", {8'd0, acc_o}, {8'd0, v[22:15]});
      check(t, "xreg", {8'd0, xreg_o}, {8'd0, v[14:7]});
      check((t == "R11") ? "R11" : "R9", "nzcv", {12'd0, fn, fz, fc, fv}, {12'd0, v[6:3]});
      check((t == "R11") ? "R11" : "R10", "write enables", {14'd0, acc_we, xreg_we}, {14'd0, v[2:1]});
      check("R11", "illegal", {15'd0, illegal}, {15'd0, v[0]});
    end

    // R12: hold while valid is low, even with new operands on the inputs
    drive(8'hAB, 8'hAA, 8'h00, 8'h55, 4'b0000, 1'b1);
    @(negedge clk);
    drive(8'hEB, 8'h01, 8'h80, 8'h00, 4'b0010, 1'b0);
    repeat (3) @(negedge clk);
    check("R12", "held acc/xreg", {acc_o, xreg_o}, 16'hAAAA);
    check("R12", "held flags/enables", {9'd0, fn, fz, fc, fv, acc_we, xreg_we, illegal}, {9'd0, 4'b1000, 2'b11, 1'b0});
    // R12: one-edge latency once valid rises
    valid = 1'b1;
    @(negedge clk);
    check("R12", "latency acc", {8'd0, acc_o}, 16'h007F);
    valid = 1'b0;

    // R5: carry-in has no effect on the compare-style subtract
    drive(8'hCB, 8'h40, 8'h3F, 8'hFF, 4'b0010, 1'b1);
    @(negedge clk);
    check("R5", "xsub carry-in 1, x", {8'd0, xreg_o}, 16'h00FF);
    check("R5", "xsub borrow C", {15'd0, fc}, 16'h0000);
    drive(8'hCB, 8'h40, 8'h3F, 8'hFF, 4'b0000, 1'b1);
    @(negedge clk);
    check("R5", "xsub carry-in 0, x", {8'd0, xreg_o}, 16'h00FF);

    // R4: zero carry-in with bit 7 set of ANDed value
    drive(8'h6B, 8'hFF, 8'hFF, 8'h00, 4'b0000, 1'b1);
    @(negedge clk);
    check("R4", "rotate acc", {8'd0, acc_o}, 16'h007F);
    check("R4", "rotate C,V", {14'd0, fc, fv}, 16'h0002);
    valid = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule